// File: doc/BRIEF.md
# Snooping MESI Coherence Cluster

This block keeps a group of small direct-mapped caches coherent over one shared broadcast bus. Every cache has its own controller. The controller holds one word per line and tracks each line as Modified, Exclusive, Shared or Invalid. A controller serves load and store requests from its processor port. When a request cannot be finished locally, the controller wins the bus through a round-robin arbiter and broadcasts a read, an invalidate or a write-back. Every other controller snoops that broadcast. A snooper with a valid copy raises a wired-OR shared indication and, for reads, drives its data onto the bus. All controllers share a single memory port for fills and write-backs.

A processor holds its request (valid, write flag, address, write data) until it sees a one-cycle response pulse, and drops the request in that same cycle. The memory behind the port must return read data on the cycle after a read request. An address splits into a line index, taken from its low log2(LINES) bits, and a tag, taken from the remaining bits.

Top module: `mesi_cluster`

## Requirements
- R1: After reset every line is Invalid. No response and no memory traffic appear until a request arrives, and the first load of any address reads it from memory.
- R2: A load that hits finishes with a response one cycle after it is accepted. It causes no memory traffic. Each response is a single-cycle pulse.
- R3: A load miss that no peer holds issues a memory read, receives the data one cycle later (3 cycles in total) and installs the line Exclusive. A following store to that line by the same cache finishes in 1 cycle without memory traffic.
- R4: A load miss on a line a peer holds is answered by the peer over the bus in 2 cycles, with no memory read. Both copies end Shared, so later loads from either cache hit in 1 cycle. A clean supplier causes no memory traffic at all.
- R5: A store to a Shared line broadcasts an invalidate and finishes in 2 cycles without memory traffic. The writer becomes Modified and every peer copy becomes Invalid, so a peer's next load returns the new value, supplied by the writer.
- R6: When a snooped read hits a Modified line, the holder supplies the data and writes it to memory in the same bus cycle (the memory write carries the line's address and value), then drops to Shared. Its next store to that line needs the bus and takes 2 cycles.
- R7: A miss whose indexed victim is Modified first writes the victim back to memory and then proceeds. A load handled this way takes 4 cycles, and a later load of the victim's address from another cache reads the written-back value from memory.
- R8: A store to a Modified line stays Modified and finishes in 1 cycle without memory traffic.
- R9: The arbiter grants the bus to at most one controller at a time, in round-robin order. The owner keeps the grant for as long as it requests it, and simultaneous requests from all caches all complete.
- R10: Two caches never hold the same address at the same time while either copy is Modified or Exclusive.
- R11: Every load returns the value most recently stored to that address by any cache, or the initial memory value if nothing has been stored.
- R12: A store miss broadcasts an invalidate and installs the line Modified without a memory read, finishing in 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | NUM_CACHES | Request valid per processor, held until the response |
| cpu_req_write | input | NUM_CACHES | 1 = store, 0 = load, per processor |
| cpu_req_addr | input | NUM_CACHES*ADDR_W | Request address, processor i at slice i |
| cpu_req_wdata | input | NUM_CACHES*DATA_W | Store data, processor i at slice i |
| cpu_resp_valid | output | NUM_CACHES | One-cycle completion pulse per processor |
| cpu_resp_rdata | output | NUM_CACHES*DATA_W | Load result, valid with the pulse |
| mem_valid | output | 1 | Memory access this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Read data, returned the cycle after a read |

## Verification
On every cycle, the assertions check the single-owner invariant across all caches and lines, the one-hot grant and the held grant of the arbiter, the single-cycle response pulse, and the absence of a memory read whenever a peer supplies a line. Only the bench's scenarios can show the remaining behaviour. That covers the Exclusive-versus-Shared outcome of a fill, a silent upgrade from Exclusive, the invalidate round on a Shared store, write-back on a snooped Modified line and on eviction, and the latest-value guarantee. The bench observes these through the latencies, the memory traffic and the returned data, over directed sequences and seeded random sequences of loads and stores.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_INV  = 2'd2,
        OP_WB   = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        C_IDLE  = 3'd0,
        C_EVICT = 3'd1,
        C_BUS   = 3'd2,
        C_FILL  = 3'd3,
        C_DONE  = 3'd4
    } ctl_st_e;

endpackage

// File: rtl/mesi_rr_arbiter.sv
module mesi_rr_arbiter #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]  owner;
        logic [IW-1:0] last;
    } arb_t;

    arb_t q, d;
    int   cand;

    always_comb begin
        d    = q;
        gnt  = '0;
        cand = 0;
        if (|(q.owner & req)) begin
            // the current owner keeps the bus until it lets go
            gnt = q.owner & req;
        end else begin
            for (int k = 1; k <= N; k++) begin
                cand = (int'(q.last) + k) % N;
                if (gnt == '0 && req[cand]) begin
                    gnt[cand] = 1'b1;
                    d.last    = IW'(cand);
                end
            end
        end
        d.owner = gnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req_valid,
    input  logic                        cpu_req_write,
    input  logic [ADDR_W-1:0]           cpu_req_addr,
    input  logic [DATA_W-1:0]           cpu_req_wdata,
    output logic                        cpu_resp_valid,
    output logic [DATA_W-1:0]           cpu_resp_rdata,
    output logic                        bus_req,
    input  logic                        bus_gnt,
    output logic                        bus_out_valid,
    output bus_op_e                     bus_out_op,
    output logic [ADDR_W-1:0]           bus_out_addr,
    output logic [DATA_W-1:0]           bus_out_data,
    input  logic                        snp_valid,
    input  bus_op_e                     snp_op,
    input  logic [ADDR_W-1:0]           snp_addr,
    output logic                        snp_hit,
    output logic                        snp_supply,
    output logic                        snp_dirty,
    output logic [DATA_W-1:0]           snp_data,
    input  logic                        bus_shared_in,
    input  logic                        bus_supply_in,
    input  logic [DATA_W-1:0]           bus_supply_data,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic [LINES*2-1:0]          line_state_o,
    output logic [LINES*(ADDR_W-$clog2(LINES))-1:0] line_tag_o
);
    localparam int IW    = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IW;

    typedef struct packed {
        ctl_st_e                      fsm;
        logic                         wr;
        logic [ADDR_W-1:0]            addr;
        logic [DATA_W-1:0]            wdata;
        logic [DATA_W-1:0]            rdata;
        line_st_e [LINES-1:0]         st;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][DATA_W-1:0] data;
    } ctl_t;

    ctl_t q, d;

    logic [IW-1:0]    s_idx, r_idx, i_idx;
    logic [TAG_W-1:0] s_tag, r_tag, i_tag;
    logic             s_hit;

    always_comb begin
        d             = q;
        bus_req       = 1'b0;
        bus_out_valid = 1'b0;
        bus_out_op    = OP_NONE;
        bus_out_addr  = q.addr;
        bus_out_data  = '0;

        // snoop side: react to another controller's broadcast
        s_idx      = snp_addr[IW-1:0];
        s_tag      = snp_addr[ADDR_W-1:IW];
        s_hit      = snp_valid && (q.st[s_idx] != ST_I) && (q.tag[s_idx] == s_tag);
        snp_hit    = s_hit;
        snp_supply = s_hit && (snp_op == OP_RD);
        snp_dirty  = snp_supply && (q.st[s_idx] == ST_M);
        snp_data   = q.data[s_idx];
        if (s_hit) begin
            if (snp_op == OP_RD)  d.st[s_idx] = ST_S;
            if (snp_op == OP_INV) d.st[s_idx] = ST_I;
        end

        r_idx = q.addr[IW-1:0];
        r_tag = q.addr[ADDR_W-1:IW];
        i_idx = cpu_req_addr[IW-1:0];
        i_tag = cpu_req_addr[ADDR_W-1:IW];

        case (q.fsm)
            C_IDLE: begin
                // a broadcast this cycle may touch the array, so wait
                if (cpu_req_valid && !snp_valid) begin
                    d.wr    = cpu_req_write;
                    d.addr  = cpu_req_addr;
                    d.wdata = cpu_req_wdata;
                    if (q.st[i_idx] != ST_I && q.tag[i_idx] == i_tag) begin
                        if (!cpu_req_write) begin
                            d.rdata = q.data[i_idx];
                            d.fsm   = C_DONE;
                        end else if (q.st[i_idx] == ST_S) begin
                            d.fsm = C_BUS;
                        end else begin
                            d.data[i_idx] = cpu_req_wdata;
                            d.st[i_idx]   = ST_M;
                            d.fsm         = C_DONE;
                        end
                    end else if (q.st[i_idx] == ST_M) begin
                        d.fsm = C_EVICT;
                    end else begin
                        d.fsm = C_BUS;
                    end
                end
            end
            C_EVICT: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    if (q.st[r_idx] == ST_M) begin
                        bus_out_valid = 1'b1;
                        bus_out_op    = OP_WB;
                        bus_out_addr  = {q.tag[r_idx], r_idx};
                        bus_out_data  = q.data[r_idx];
                    end
                    d.st[r_idx] = ST_I;
                    d.fsm       = C_BUS;
                end
            end
            C_BUS: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_out_valid = 1'b1;
                    bus_out_op    = q.wr ? OP_INV : OP_RD;
                    if (q.wr) begin
                        d.tag[r_idx]  = r_tag;
                        d.data[r_idx] = q.wdata;
                        d.st[r_idx]   = ST_M;
                        d.fsm         = C_DONE;
                    end else if (bus_supply_in) begin
                        d.tag[r_idx]  = r_tag;
                        d.data[r_idx] = bus_supply_data;
                        d.rdata       = bus_supply_data;
                        d.st[r_idx]   = bus_shared_in ? ST_S : ST_E;
                        d.fsm         = C_DONE;
                    end else begin
                        d.fsm = C_FILL;
                    end
                end
            end
            C_FILL: begin
                bus_req       = 1'b1;
                d.tag[r_idx]  = r_tag;
                d.data[r_idx] = mem_rdata;
                d.rdata       = mem_rdata;
                d.st[r_idx]   = ST_E;
                d.fsm         = C_DONE;
            end
            C_DONE:  d.fsm = C_IDLE;
            default: d.fsm = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cpu_resp_valid = (q.fsm == C_DONE);
    assign cpu_resp_rdata = q.rdata;

    for (genvar l = 0; l < LINES; l++) begin : g_obs
        assign line_state_o[l*2 +: 2]        = q.st[l];
        assign line_tag_o[l*TAG_W +: TAG_W]  = q.tag[l];
    end

endmodule

// File: rtl/mesi_cluster.sv
module mesi_cluster
    import mesi_pkg::*;
#(
    parameter int NUM_CACHES = 2,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int LINES      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CACHES-1:0]        cpu_req_valid,
    input  logic [NUM_CACHES-1:0]        cpu_req_write,
    input  logic [NUM_CACHES*ADDR_W-1:0] cpu_req_addr,
    input  logic [NUM_CACHES*DATA_W-1:0] cpu_req_wdata,
    output logic [NUM_CACHES-1:0]        cpu_resp_valid,
    output logic [NUM_CACHES*DATA_W-1:0] cpu_resp_rdata,
    output logic                         mem_valid,
    output logic                         mem_write,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata
);
    localparam int N     = NUM_CACHES;
    localparam int IW    = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IW;

    logic [N-1:0]        bus_req, bus_gnt, out_valid;
    logic [N-1:0]        c_hit, c_supply, c_dirty, snp_valid;
    bus_op_e             out_op   [N];
    logic [ADDR_W-1:0]   out_addr [N];
    logic [DATA_W-1:0]   out_data [N];
    logic [DATA_W-1:0]   c_sdata  [N];
    logic [N*LINES*2-1:0]     all_state;
    logic [N*LINES*TAG_W-1:0] all_tag;

    logic                bus_valid, bus_shared, bus_supply, bus_sdirty;
    bus_op_e             bus_op;
    logic [ADDR_W-1:0]   bus_addr;
    logic [DATA_W-1:0]   bus_data, bus_sdata;

    mesi_rr_arbiter #(.N(N)) u_arb (
        .clk (clk),
        .rst_n(rst_n),
        .req (bus_req),
        .gnt (bus_gnt)
    );

    for (genvar i = 0; i < N; i++) begin : g_cache
        assign snp_valid[i] = bus_valid && !bus_gnt[i];

        mesi_cache_ctrl #(
            .ADDR_W(ADDR_W),
            .DATA_W(DATA_W),
            .LINES (LINES)
        ) u_ctrl (
            .clk            (clk),
            .rst_n          (rst_n),
            .cpu_req_valid  (cpu_req_valid[i]),
            .cpu_req_write  (cpu_req_write[i]),
            .cpu_req_addr   (cpu_req_addr[i*ADDR_W +: ADDR_W]),
            .cpu_req_wdata  (cpu_req_wdata[i*DATA_W +: DATA_W]),
            .cpu_resp_valid (cpu_resp_valid[i]),
            .cpu_resp_rdata (cpu_resp_rdata[i*DATA_W +: DATA_W]),
            .bus_req        (bus_req[i]),
            .bus_gnt        (bus_gnt[i]),
            .bus_out_valid  (out_valid[i]),
            .bus_out_op     (out_op[i]),
            .bus_out_addr   (out_addr[i]),
            .bus_out_data   (out_data[i]),
            .snp_valid      (snp_valid[i]),
            .snp_op         (bus_op),
            .snp_addr       (bus_addr),
            .snp_hit        (c_hit[i]),
            .snp_supply     (c_supply[i]),
            .snp_dirty      (c_dirty[i]),
            .snp_data       (c_sdata[i]),
            .bus_shared_in  (bus_shared),
            .bus_supply_in  (bus_supply),
            .bus_supply_data(bus_sdata),
            .mem_rdata      (mem_rdata),
            .line_state_o   (all_state[i*LINES*2 +: LINES*2]),
            .line_tag_o     (all_tag[i*LINES*TAG_W +: LINES*TAG_W])
        );
    end

    // broadcast mux from the granted controller, wired-OR snoop replies
    always_comb begin
        bus_valid  = 1'b0;
        bus_op     = OP_NONE;
        bus_addr   = '0;
        bus_data   = '0;
        bus_supply = 1'b0;
        bus_sdirty = 1'b0;
        bus_sdata  = '0;
        for (int i = 0; i < N; i++) begin
            if (bus_gnt[i] && out_valid[i]) begin
                bus_valid = 1'b1;
                bus_op    = out_op[i];
                bus_addr  = out_addr[i];
                bus_data  = out_data[i];
            end
        end
        bus_shared = |c_hit;
        for (int i = N - 1; i >= 0; i--) begin
            if (c_supply[i]) begin
                bus_supply = 1'b1;
                bus_sdirty = c_dirty[i];
                bus_sdata  = c_sdata[i];
            end
        end
    end

    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = bus_addr;
        mem_wdata = bus_data;
        if (bus_valid && bus_op == OP_WB) begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
        end else if (bus_valid && bus_op == OP_RD) begin
            if (bus_supply && bus_sdirty) begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = bus_sdata;
            end else if (!bus_supply) begin
                mem_valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mesi_cluster_checker.sv
module mesi_cluster_checker
    import mesi_pkg::*;
#(
    parameter int N     = 2,
    parameter int LINES = 4,
    parameter int TAG_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N-1:0]             bus_req,
    input logic [N-1:0]             bus_gnt,
    input logic [N-1:0]             cpu_resp_valid,
    input logic                     bus_valid,
    input bus_op_e                  bus_op,
    input logic                     bus_supply,
    input logic                     mem_valid,
    input logic                     mem_write,
    input logic [N*LINES*2-1:0]     all_state,
    input logic [N*LINES*TAG_W-1:0] all_tag
);

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_gnt)) else $error("grant not one-hot"); // R9

    AST_NO_MEMRD_ON_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_op == OP_RD && bus_supply) |-> !(mem_valid && !mem_write))
        else $error("memory read while a peer supplies"); // R4

    for (genvar i = 0; i < N; i++) begin : g_port
        AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_req[i] && $past(bus_gnt[i] && bus_req[i])) |-> bus_gnt[i])
            else $error("owner lost the bus mid-transaction"); // R9

        AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_resp_valid[i] |=> !cpu_resp_valid[i])
            else $error("response longer than one cycle"); // R2
    end

    for (genvar i = 0; i < N; i++) begin : g_a
        for (genvar j = i + 1; j < N; j++) begin : g_b
            for (genvar l = 0; l < LINES; l++) begin : g_line
                AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
                    !((all_state[(i*LINES+l)*2 +: 2] != 2'(ST_I))
                      && (all_state[(j*LINES+l)*2 +: 2] != 2'(ST_I))
                      && (all_tag[(i*LINES+l)*TAG_W +: TAG_W] == all_tag[(j*LINES+l)*TAG_W +: TAG_W])
                      && (all_state[(i*LINES+l)*2+1] || all_state[(j*LINES+l)*2+1])))
                    else $error("two caches own one line"); // R10
            end
        end
    end

endmodule

bind mesi_cluster mesi_cluster_checker #(
    .N    (NUM_CACHES),
    .LINES(LINES),
    .TAG_W(TAG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .cpu_resp_valid(cpu_resp_valid),
    .bus_valid     (bus_valid),
    .bus_op        (bus_op),
    .bus_supply    (bus_supply),
    .mem_valid     (mem_valid),
    .mem_write     (mem_write),
    .all_state     (all_state),
    .all_tag       (all_tag)
);

// File: tb/mesi_cluster_bench.sv
`timescale 1ns/1ps
module mesi_cluster_bench;
    localparam int N  = 2;
    localparam int AW = 8;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    cpu_req_valid = '0;
    logic [N-1:0]    cpu_req_write = '0;
    logic [N*AW-1:0] cpu_req_addr  = '0;
    logic [N*DW-1:0] cpu_req_wdata = '0;
    logic [N-1:0]    cpu_resp_valid;
    logic [N*DW-1:0] cpu_resp_rdata;
    logic            mem_valid, mem_write;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [AW-1:0] last_wa = '0;
    logic [DW-1:0] last_wd = '0;
    bit  finished = 0;

    logic [DW-1:0] mem_model [256];
    logic [DW-1:0] ref_mem   [256];

    always #2 clk = ~clk;

    mesi_cluster u_mesi_cluster (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .cpu_req_addr  (cpu_req_addr),
        .cpu_req_wdata (cpu_req_wdata),
        .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata),
        .mem_valid     (mem_valid),
        .mem_write     (mem_write),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata)
    );

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return {a, ~a} ^ 16'h3c5a;
    endfunction

    // memory model: read data appears the cycle after the request
    always @(posedge clk) begin
        if (rst_n && mem_valid) begin
            if (mem_write) begin
                mem_model[mem_addr] <= mem_wdata;
                wr_cnt  <= wr_cnt + 1;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
            end else begin
                mem_rdata <= mem_model[mem_addr];
                rd_cnt    <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input int c, input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd, output int lat);
        cpu_req_valid[c] = 1'b1;
        cpu_req_write[c] = wr;
        cpu_req_addr[c*AW +: AW]  = a;
        cpu_req_wdata[c*DW +: DW] = wd;
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!cpu_resp_valid[c]);
        rd = cpu_resp_rdata[c*DW +: DW];
        cpu_req_valid[c] = 1'b0;
        if (wr) ref_mem[a] = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    // one operation with expected latency and memory traffic deltas (-1 skips)
    task automatic op_chk(input string rq, input int c, input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input int exp_lat, input int exp_rd, input int exp_wr);
        logic [DW-1:0] rd;
        logic [DW-1:0] expv;
        int lat;
        int r0;
        int w0;
        r0 = rd_cnt;
        w0 = wr_cnt;
        expv = ref_mem[a];
        do_op(c, wr, a, wd, rd, lat);
        if (!wr)          chk(rq, "load data", int'(rd), int'(expv));
        if (exp_lat >= 0) chk(rq, "latency", lat, exp_lat);
        if (exp_rd >= 0)  chk(rq, "memory reads", rd_cnt - r0, exp_rd);
        if (exp_wr >= 0)  chk(rq, "memory writes", wr_cnt - w0, exp_wr);
    endtask

    task automatic rand_seq(input int count);
        for (int k = 0; k < count; k++) begin
            int c = int'($urandom % 2);
            bit wr = ($urandom % 3) == 0;
            logic [AW-1:0] a = 8'h80 + AW'($urandom % 16);
            logic [DW-1:0] wd = DW'($urandom);
            op_chk("R11", c, wr, a, wd, -1, -1, -1);
        end
    endtask

    task automatic rand_port(input int c, input int count);
        for (int k = 0; k < count; k++) begin
            bit wr = ($urandom % 2) == 0;
            logic [AW-1:0] a = 8'hC0 + AW'(c) + AW'(2 * ($urandom % 8));
            logic [DW-1:0] wd = DW'($urandom);
            logic [DW-1:0] expv = ref_mem[a];
            logic [DW-1:0] rd;
            int lat;
            do_op(c, wr, a, wd, rd, lat);
            if (!wr) chk("R11", "concurrent load data", int'(rd), int'(expv));
        end
    endtask

    initial begin
        logic [DW-1:0] r0v;
        logic [DW-1:0] r1v;
        int l0;
        int l1;
        int seed;
        seed = int'($urandom(32'd2024));
        for (int a = 0; a < 256; a++) begin
            mem_model[a] = init_val(AW'(a));
            ref_mem[a]   = init_val(AW'(a));
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1", "idle response", int'(cpu_resp_valid), 0);
            chk("R1", "idle memory", int'(mem_valid), 0);
        end

        // exclusive fill, silent hits and upgrade
        op_chk("R3", 0, 1'b0, 8'h10, 16'h0, 3, 1, 0);
        op_chk("R2", 0, 1'b0, 8'h10, 16'h0, 1, 0, 0);
        op_chk("R3", 0, 1'b1, 8'h10, 16'h1111, 1, 0, 0);
        op_chk("R8", 0, 1'b1, 8'h10, 16'h2222, 1, 0, 0);

        // snooped read of a Modified line
        op_chk("R6", 1, 1'b0, 8'h10, 16'h0, 2, 0, 1);
        chk("R6", "write-back address", int'(last_wa), 'h10);
        chk("R6", "write-back data", int'(last_wd), 'h2222);
        op_chk("R4", 0, 1'b0, 8'h10, 16'h0, 1, 0, 0);
        op_chk("R4", 1, 1'b0, 8'h10, 16'h0, 1, 0, 0);

        // store to Shared invalidates the peer
        op_chk("R5", 0, 1'b1, 8'h10, 16'h3333, 2, 0, 0);
        op_chk("R5", 1, 1'b0, 8'h10, 16'h0, 2, 0, 1);
        op_chk("R6", 0, 1'b1, 8'h10, 16'h4444, 2, 0, 0);
        op_chk("R5", 1, 1'b0, 8'h10, 16'h0, 2, 0, 1);

        // clean supplier
        op_chk("R3", 0, 1'b0, 8'h21, 16'h0, 3, 1, 0);
        op_chk("R4", 1, 1'b0, 8'h21, 16'h0, 2, 0, 0);
        op_chk("R4", 0, 1'b0, 8'h21, 16'h0, 1, 0, 0);

        // store miss, then eviction of a Modified victim (same index 2)
        op_chk("R12", 0, 1'b1, 8'h32, 16'h5555, 2, 0, 0);
        op_chk("R7", 0, 1'b0, 8'h42, 16'h0, 4, 1, 1);
        chk("R7", "victim address", int'(last_wa), 'h32);
        chk("R7", "victim data", int'(last_wd), 'h5555);
        op_chk("R7", 1, 1'b0, 8'h32, 16'h0, 3, 1, 0);

        // simultaneous misses, different and equal addresses
        fork
            do_op(0, 1'b0, 8'h63, 16'h0, r0v, l0);
            do_op(1, 1'b0, 8'h73, 16'h0, r1v, l1);
        join
        chk("R9", "cache0 data", int'(r0v), int'(init_val(8'h63)));
        chk("R9", "cache1 data", int'(r1v), int'(init_val(8'h73)));
        fork
            do_op(0, 1'b0, 8'h93, 16'h0, r0v, l0);
            do_op(1, 1'b0, 8'h93, 16'h0, r1v, l1);
        join
        chk("R9", "same line cache0", int'(r0v), int'(init_val(8'h93)));
        chk("R9", "same line cache1", int'(r1v), int'(init_val(8'h93)));
        op_chk("R4", 0, 1'b0, 8'h93, 16'h0, 1, 0, 0);
        op_chk("R4", 1, 1'b0, 8'h93, 16'h0, 1, 0, 0);

        // seeded random traffic, serial then concurrent on disjoint sets
        rand_seq(300);
        fork
            rand_port(0, 80);
            rand_port(1, 80);
        join
        for (int a = 8'hC0; a < 8'hD0; a++)
            op_chk("R11", a % 2, 1'b0, AW'(a), 16'h0, -1, -1, -1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule